// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable behavioural model of a synchronous burst SRAM that needs no idle cycle between reads and writes. Each rising clock edge is decoded into one of these cycles: deselect, read, dummy read, write, write abort, stall or sleep. The decode looks at a combined chip enable, an advance/load select, a write enable, four byte-write selects, a clock enable and a sleep input. A 2-bit linear burst counter steps the low address bits during continue cycles. The controller drives the shared data bus or releases it to high impedance.

Reads and writes share one two-stage pipeline. A read places its word on the bus in the same bus slot in which a write of the same age would take its data. Read, write, read, write can therefore follow each other on consecutive edges with no gap. The output enable acts asynchronously on the bus drivers only. A read fetched on the edge where an older write to the same word completes returns the newly written lanes.

Top module: `burst_sram_ctrl`

## Requirements
- R1: On an edge with `clk_en_n` high and `sleep` low, nothing changes: the pipeline, burst address, read register and memory all keep their values, and the bus keeps its current drive or release.
- R2: On an active edge with `adv_ld` low and `chip_en_n` high, a deselect is issued. With `adv_ld` high after a deselect, the deselect continues whatever `chip_en_n` and `wr_en_n` are. A deselect never drives the bus.
- R3: On an active edge with `adv_ld` low and `chip_en_n` low, `addr` is loaded and a burst begins: a read if `wr_en_n` is high, a write if it is low. With `adv_ld` high, the previous read or write continues at the next burst address. That address adds one to the two low address bits modulo 4 and keeps the upper bits. `chip_en_n` and `wr_en_n` are ignored in that cycle.
- R4: A write cycle, loaded or continued, in which all four `byte_wr_n` bits are high (inactive) changes no memory word and leaves the bus released.
- R5: Lane i is `dq[9*i+8 : 9*i]` (8 data bits plus 1 parity bit). A write updates lane i only when `byte_wr_n[i]` is low on that write's address edge. The other lanes keep their old contents.
- R6: Count only active edges. A read issued on edge k drives its word on `dq` from just after edge k+1 until edge k+2. A write issued on edge k stores `dq` at edge k+2.
- R7: `out_en_n` acts asynchronously. The read word is on the bus only while `out_en_n` is low. A read with `out_en_n` high is a dummy read with the bus released. The block never drives the bus during a write data slot.
- R8: While `sleep` is high the bus is released at once. Any edge with `sleep` high cancels every operation in flight, including a pending write, and leaves the block deselected.
- R9: During and after reset the block is deselected and the bus is released, even with `out_en_n` low.
- R10: A read fetched on the edge where an older write to the same word completes returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en_n | input | 1 | Combined chip enable, active low |
| adv_ld | input | 1 | High: continue burst; low: load new cycle |
| wr_en_n | input | 1 | Write enable for load cycles, active low |
| byte_wr_n | input | LANES (4) | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| clk_en_n | input | 1 | Clock enable, active low; high inserts a wait state |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W (6) | Word address |
| dq | inout | LANES*LANE_W (36) | Data bus, lane i at bits 9*i+8 : 9*i |

## Verification
The memory is first filled by write bursts from aligned addresses. It is then read back with a burst loaded at an unaligned address, which separates a wrapping counter from a carrying one. Alternating single reads and writes on consecutive edges test the bus slot timing. A write immediately followed by a read of the same word, and a write burst followed at once by a read burst over it, test the forwarding path. Partial and all-inactive byte selects test lane masking against aborts. Stalls, output-enable changes in mid-cycle, sleep in the middle of a burst and a final stretch of mixed random cycles check that the bus is held, released and flushed at the right moments.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Kind of cycle held in each pipeline stage.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Number of low address bits that the burst counter steps.
  localparam int BURST_W = 2;

  // Linear burst step: wraps inside an aligned group of 2**BURST_W words.
  function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] cnt);
    return cnt + BURST_W'(1);
  endfunction

  // Decoded cycle kind for a load edge.
  function automatic op_e load_kind(input logic sel_n, input logic we_n);
    if (sel_n) return OP_NONE;
    return we_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              chip_en_n,
  input  logic              adv_ld,
  input  logic              wr_en_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  op_e               prev_op,
  input  logic [ADDR_W-1:0] prev_addr,
  output op_e               cyc_op,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [LANES-1:0]  cyc_mask
);

  function automatic logic [ADDR_W-1:0] next_burst_addr(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BURST_W], burst_step(a[BURST_W-1:0])};
  endfunction

  always_comb begin
    if (!adv_ld) begin
      cyc_op   = load_kind(chip_en_n, wr_en_n);
      cyc_addr = ext_addr;
    end else begin
      // continue: chip enable and write enable are not looked at
      cyc_op   = prev_op;
      cyc_addr = next_burst_addr(prev_addr);
    end
    cyc_mask = (cyc_op == OP_WRITE) ? ~byte_wr_n : '0;
  end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              flush,
  input  op_e               cyc_op,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [LANES-1:0]  cyc_mask,
  output op_e               a_op,
  output logic [ADDR_W-1:0] a_addr,
  output logic [LANES-1:0]  a_mask,
  output op_e               b_op,
  output logic [ADDR_W-1:0] b_addr,
  output logic [LANES-1:0]  b_mask
);

  // Stage A: cycle issued on the last active edge (also the burst origin).
  // Stage B: cycle whose bus slot is open now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op   <= OP_NONE;
      a_addr <= '0;
      a_mask <= '0;
      b_op   <= OP_NONE;
      b_addr <= '0;
      b_mask <= '0;
    end else if (flush) begin
      a_op   <= OP_NONE;
      a_mask <= '0;
      b_op   <= OP_NONE;
      b_mask <= '0;
    end else if (advance) begin
      a_op   <= cyc_op;
      a_addr <= cyc_addr;
      a_mask <= cyc_mask;
      b_op   <= a_op;
      b_addr <= a_addr;
      b_mask <= a_mask;
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic addr_match;
  assign addr_match = (wr_addr == rd_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] wr_lane;
    logic [LANE_W-1:0] rd_lane;
    logic              lane_we;
    logic              lane_fwd;

    assign wr_lane  = wr_data[i*LANE_W +: LANE_W];
    assign lane_we  = advance && wr_en && wr_mask[i];
    assign lane_fwd = lane_we && addr_match;

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[wr_addr] <= wr_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rd_lane <= '0;
      else if (advance && rd_en)
        rd_lane <= lane_fwd ? wr_lane : lane_mem[rd_addr];
    end

    assign rd_data[i*LANE_W +: LANE_W] = rd_lane;
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip_en_n,
  input  logic                    adv_ld,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic                    out_en_n,
  input  logic                    clk_en_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DQ_W = LANES * LANE_W;

  op_e               cyc_op, a_op, b_op;
  logic [ADDR_W-1:0] cyc_addr, a_addr, b_addr;
  logic [LANES-1:0]  cyc_mask, a_mask, b_mask;
  logic [DQ_W-1:0]   rd_word;

  // Named events
  logic evt_active;   // edge that advances the pipeline
  logic evt_fetch;    // stage A read fetched on this edge
  logic evt_store;    // stage B write slot closes on this edge
  logic bus_oe;       // block drives dq

  assign evt_active = !clk_en_n && !sleep;
  assign evt_fetch  = (a_op == OP_READ);
  assign evt_store  = (b_op == OP_WRITE);

  sram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .chip_en_n (chip_en_n),
    .adv_ld    (adv_ld),
    .wr_en_n   (wr_en_n),
    .byte_wr_n (byte_wr_n),
    .ext_addr  (addr),
    .prev_op   (a_op),
    .prev_addr (a_addr),
    .cyc_op    (cyc_op),
    .cyc_addr  (cyc_addr),
    .cyc_mask  (cyc_mask)
  );

  sram_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (evt_active),
    .flush    (sleep),
    .cyc_op   (cyc_op),
    .cyc_addr (cyc_addr),
    .cyc_mask (cyc_mask),
    .a_op     (a_op),
    .a_addr   (a_addr),
    .a_mask   (a_mask),
    .b_op     (b_op),
    .b_addr   (b_addr),
    .b_mask   (b_mask)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (evt_active),
    .wr_en   (evt_store),
    .wr_addr (b_addr),
    .wr_mask (b_mask),
    .wr_data (dq),
    .rd_en   (evt_fetch),
    .rd_addr (a_addr),
    .rd_data (rd_word)
  );

  // Output enable and sleep act on the drivers without a clock.
  assign bus_oe = (b_op == OP_READ) && !out_en_n && !sleep;
  assign dq     = bus_oe ? rd_word : {DQ_W{1'bz}};

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              clk_en_n,
  input logic              adv_ld,
  input logic              chip_en_n,
  input logic              wr_en_n,
  input logic [LANES-1:0]  byte_wr_n,
  input op_e               a_op,
  input logic [ADDR_W-1:0] a_addr,
  input logic [LANES-1:0]  a_mask,
  input op_e               b_op
);

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep) |=> ($stable(a_op) && $stable(b_op) && $stable(a_addr)));

  assert_deselect_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !clk_en_n && !adv_ld && chip_en_n) |=> (a_op == OP_NONE));

  assert_read_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !clk_en_n && !adv_ld && !chip_en_n && wr_en_n) |=> (a_op == OP_READ));

  assert_burst_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !clk_en_n && adv_ld && a_op != OP_NONE) |=>
      ((a_addr[1:0] == $past(a_addr[1:0]) + 2'd1) &&
       (a_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2]))));

  assert_write_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !clk_en_n && !adv_ld && !chip_en_n && !wr_en_n && (&byte_wr_n)) |=>
      (a_op == OP_WRITE && a_mask == '0));

  assert_read_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !clk_en_n && a_op == OP_READ) |=> (b_op == OP_READ));

  assert_sleep_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (a_op == OP_NONE && b_op == OP_NONE));

endmodule

bind burst_sram_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep     (sleep),
  .clk_en_n  (clk_en_n),
  .adv_ld    (adv_ld),
  .chip_en_n (chip_en_n),
  .wr_en_n   (wr_en_n),
  .byte_wr_n (byte_wr_n),
  .a_op      (a_op),
  .a_addr    (a_addr),
  .a_mask    (a_mask),
  .b_op      (b_op)
);

// File: tb/test_burst_sram_ctrl.sv
`timescale 1ns/1ps
module test_burst_sram_ctrl;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NWORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, adv = 1'b0, we_n = 1'b1, oe_n = 1'b0, cen_n = 1'b0, slp = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] tb_bus = '0;
  logic tb_drv = 1'b0;
  wire  [DW-1:0] dq;

  assign dq = tb_drv ? tb_bus : {DW{1'bz}};
  always #2.5 clk = ~clk;

  burst_sram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .adv_ld(adv), .wr_en_n(we_n),
    .byte_wr_n(bw_n), .out_en_n(oe_n), .clk_en_n(cen_n), .sleep(slp),
    .addr(a), .dq(dq)
  );

  // Reference model: op 0 = nothing, 1 = read, 2 = write
  typedef struct {
    int            op;
    int            addr;
    logic [NL-1:0] mask;
    logic [DW-1:0] data;
    string         tag;
  } ent_t;

  ent_t          pipe[$];          // [0] = bus slot now, [1] = last issued
  logic [DW-1:0] ref_mem [NWORDS];
  logic [DW-1:0] rd_val = '0;
  string         rd_tag = "R6";
  string         phase  = "R3";
  bit            stalled = 1'b0;
  logic          g_oe = 1'b0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  function automatic ent_t idle_ent();
    ent_t e;
    e.op = 0; e.addr = 0; e.mask = '0; e.data = '0; e.tag = "R2";
    return e;
  endfunction

  function automatic logic [DW-1:0] pat(input int x);
    logic [31:0] h;
    h = x * 32'h9E3779B1 + 32'h1234_5678;
    return {h[31:28] ^ 4'(x), h};
  endfunction

  task automatic check_bus();
    logic [DW-1:0] exp;
    string why;
    if (tb_drv) return;
    exp = {DW{1'bz}};
    if (pipe[0].op == 1 && !oe_n && !slp) exp = rd_val;
    if (slp)                why = "R8";
    else if (stalled)       why = "R1";
    else if (pipe[0].op == 1) why = oe_n ? "R7" : rd_tag;
    else if (pipe[0].op == 2) why = "R4";
    else                    why = "R2";
    n_chk++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s: dq=%h expected=%h at %0t", why, dq, exp, $time);
    end
  endtask

  task automatic model_edge(input logic c_ce_n, input logic c_adv, input logic c_we_n,
                            input logic [NL-1:0] c_bw_n, input logic c_cen_n,
                            input logic c_slp, input int c_addr, input logic [DW-1:0] c_wd);
    ent_t nx, old;
    if (c_slp) begin
      pipe[0] = idle_ent();
      pipe[1] = idle_ent();
      stalled = 1'b0;
    end else if (c_cen_n) begin
      stalled = 1'b1;
    end else begin
      stalled = 1'b0;
      old = pipe[0];
      if (old.op == 2)
        for (int k = 0; k < NL; k++)
          if (old.mask[k]) ref_mem[old.addr][k*LW +: LW] = old.data[k*LW +: LW];
      if (pipe[1].op == 1) begin
        rd_val = ref_mem[pipe[1].addr];
        rd_tag = (old.op == 2 && old.mask != 0 && old.addr == pipe[1].addr) ? "R10" : pipe[1].tag;
      end
      nx = idle_ent();
      nx.tag  = phase;
      nx.data = c_wd;
      if (!c_adv) begin
        nx.addr = c_addr;
        nx.op   = c_ce_n ? 0 : (c_we_n ? 1 : 2);
      end else begin
        nx.op   = pipe[1].op;
        nx.addr = (pipe[1].addr & ~3) | ((pipe[1].addr + 1) & 3);
      end
      if (nx.op == 2) nx.mask = ~c_bw_n;
      void'(pipe.pop_front());
      pipe.push_back(nx);
    end
    tb_drv = (pipe[0].op == 2) && (pipe[0].mask != 0);
    tb_bus = pipe[0].data;
  endtask

  task automatic cyc(input logic c_ce_n, input logic c_adv, input logic c_we_n,
                     input logic [NL-1:0] c_bw_n, input logic c_cen_n, input logic c_slp,
                     input int c_addr, input logic [DW-1:0] c_wd);
    @(negedge clk);
    ce_n = c_ce_n; adv = c_adv; we_n = c_we_n; bw_n = c_bw_n;
    cen_n = c_cen_n; slp = c_slp; a = AW'(c_addr); oe_n = g_oe;
    #1 check_bus();
    @(posedge clk);
    #0.2;
    model_edge(c_ce_n, c_adv, c_we_n, c_bw_n, c_cen_n, c_slp, c_addr, c_wd);
    #0.8 check_bus();
  endtask

  task automatic do_write(input int ad, input logic [NL-1:0] bw, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b0, bw, 1'b0, 1'b0, ad, d);
  endtask
  task automatic do_read(input int ad);
    cyc(1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, ad, '0);
  endtask
  // continue with chip enable and write enable at their "wrong" levels
  task automatic do_cont(input logic [NL-1:0] bw, input logic [DW-1:0] d);
    cyc(1'b1, 1'b1, 1'b1, bw, 1'b0, 1'b0, 0, d);
  endtask
  task automatic do_desel();
    cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 0, '0);
  endtask
  task automatic do_desel_cont();
    cyc(1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 0, '0);
  endtask
  task automatic do_stall();
    cyc(1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 7, '0);
  endtask
  task automatic do_sleep();
    cyc(1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 9, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete after 20000 cycles, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pipe.push_back(idle_ent());
    pipe.push_back(idle_ent());

    // R9: reset with output enable active
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (dq !== {DW{1'bz}}) begin
        n_fail++;
        $display("FAIL R9: dq=%h expected=%h during reset", dq, {DW{1'bz}});
      end
    end
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1;
    n_chk++;
    if (dq !== {DW{1'bz}}) begin
      n_fail++;
      $display("FAIL R9: dq=%h expected=%h after reset", dq, {DW{1'bz}});
    end

    // R3: fill memory with write bursts from aligned addresses
    phase = "R3";
    for (int blk = 0; blk < NWORDS / 4; blk++) begin
      do_write(blk * 4, 4'b0000, pat(blk * 4));
      for (int j = 1; j < 4; j++) do_cont(4'b0000, pat(blk * 4 + j));
    end
    do_desel(); do_desel();

    // R3: read burst from unaligned address wraps 5,6,7,4
    do_read(5); do_cont(4'b1111, '0); do_cont(4'b1111, '0); do_cont(4'b1111, '0);
    do_desel(); do_desel();

    // R6: back-to-back reads and writes, no gap
    phase = "R6";
    do_read(1); do_write(2, 4'b0000, pat(302)); do_read(3); do_write(4, 4'b0000, pat(304));
    do_read(2); do_read(4); do_desel(); do_desel();

    // R5: partial lane write (lanes 0 and 2 enabled)
    phase = "R5";
    do_write(10, 4'b1010, pat(110)); do_desel(); do_desel();
    do_read(10); do_desel(); do_desel();

    // R4: write abort on load and continue
    phase = "R4";
    do_write(11, 4'b1111, pat(999)); do_cont(4'b1111, pat(998)); do_desel(); do_desel();
    do_read(11); do_cont(4'b1111, '0); do_desel(); do_desel();

    // R10: read right behind a write to the same word, single and burst
    phase = "R10";
    do_write(20, 4'b0000, pat(220)); do_read(20); do_desel(); do_desel();
    do_write(24, 4'b0110, pat(224)); do_cont(4'b0000, pat(225));
    do_read(24); do_cont(4'b1111, '0); do_desel(); do_desel();

    // R7: dummy read and asynchronous output enable
    phase = "R7";
    g_oe = 1'b1; do_read(3); do_desel(); do_desel();
    g_oe = 1'b0; do_read(4); do_desel();
    g_oe = 1'b1; do_desel();
    g_oe = 1'b0; do_desel();

    // R1: stall holds read data and delays a write slot
    phase = "R1";
    do_read(30); do_desel(); do_stall(); do_stall(); do_desel(); do_desel();
    do_write(31, 4'b0000, pat(331)); do_stall(); do_stall(); do_desel(); do_desel();
    do_read(31); do_desel(); do_desel();

    // R8: sleep in the middle of a read burst, then continue stays idle
    phase = "R8";
    do_read(40); do_cont(4'b1111, '0); do_sleep(); do_sleep(); do_cont(4'b1111, '0);
    do_desel();
    do_write(41, 4'b0000, pat(441)); do_desel(); do_sleep(); do_desel();
    do_read(41); do_desel(); do_desel();

    // R2: continue after deselect with enables active stays deselected
    phase = "R2";
    do_desel(); do_desel_cont(); do_desel_cont(); do_desel();

    // R6: mixed random cycles
    phase = "R6";
    for (int i = 0; i < 150; i++) begin
      int r;
      r = int'($urandom % 10);
      g_oe = ($urandom % 4) == 0;
      case (r)
        0:       do_desel();
        1, 2:    do_cont(NL'($urandom), pat(1000 + i));
        3:       do_stall();
        4, 5:    do_read(int'($urandom % NWORDS));
        6, 7:    do_write(int'($urandom % NWORDS), NL'($urandom), pat(2000 + i));
        8:       do_desel_cont();
        default: do_sleep();
      endcase
    end
    g_oe = 1'b0;
    do_desel(); do_desel();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule